// File: doc/BRIEF.md
# Strobed Latch One-Hot Decoder

This block holds a small binary code in a register that a strobe controls, and turns the held code into a one-hot select bus. While the strobe is high, the register loads the input code on every system clock edge. The decoder also sees the input code directly during that time, so the select bus follows the data with no added cycle. While the strobe is low, the register keeps the code it loaded last, and changes on the data input have no effect.

An active-high inhibit forces every select line to its inactive level, whatever the data and strobe inputs are doing. The inhibit acts after the decoder. It never changes the held code, so when inhibit is released the bus shows the decode of whatever the register holds at that moment. A compile-time parameter sets the output polarity. With one setting, the selected line is 1 and the other lines are 0. With the other setting, the selected line is 0 and the other lines are 1.

Typical uses are address or control decoding where a code is loaded once and then kept while the source bus moves on.

Top module: `strobe_latch_decoder`

## Requirements
- R1: While rst_n is low the held code is zero, so after reset with strobe and inhibit low the bus selects line 0.
- R2: While strobe is 1 the bus decodes data_in in the same cycle, with no register in the path.
- R3: On each rising clk edge with strobe at 1 the held code takes the value of data_in. A single-cycle strobe pulse leaves that cycle's data held.
- R4: While strobe is 0, changes on data_in do not change the held code or the bus.
- R5: With POLARITY set to POL_HIGH (0), exactly one bit of sel_out is 1 and the other bits are 0, unless inhibit is high.
- R6: With POLARITY set to POL_LOW (1), exactly one bit of sel_out is 0 and the other bits are 1, unless inhibit is high.
- R7: While inhibit is 1, every bit of sel_out is at the inactive level (all 0 for POL_HIGH, all 1 for POL_LOW), with strobe high or low and for any data.
- R8: Inhibit does not disturb the held code. Right after inhibit falls with strobe low, the bus shows the code that was held before inhibit rose.
- R9: data_in[0] is the least significant bit of the code. Code value n drives the active level onto sel_out[n].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the held code updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears the held code |
| data_in | input | CODE_W (4) | Code to decode; bit 0 is least significant |
| strobe | input | 1 | 1 = load and pass data through, 0 = hold |
| inhibit | input | 1 | 1 = drive every select line inactive |
| sel_out | output | 2**CODE_W (16) | One-hot select bus, polarity set by POLARITY |

## Verification
The bench builds two copies side by side with the default 4-bit code. One copy uses POL_HIGH and the other uses POL_LOW, and both are driven with the same stimulus. This lets each inhibit and hold scenario be compared across the two polarity settings. Because the code width is 4, the bench can step through all sixteen codes with the strobe open. It also covers single-cycle strobe pulses and inhibit windows with the strobe both open and closed.

// File: rtl/sld_pkg.sv
package sld_pkg;
  typedef enum logic {POL_HIGH = 1'b0, POL_LOW = 1'b1} pol_e;

  // level driven on a line given whether it is selected
  function automatic logic line_level(input logic selected, input pol_e pol);
    return selected ^ (pol == POL_LOW);
  endfunction

  // level every line takes while inhibited
  function automatic logic idle_level(input pol_e pol);
    return (pol == POL_LOW);
  endfunction
endpackage

// File: rtl/sld_code_hold.sv
module sld_code_hold #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [CODE_W-1:0] data_in,
  output logic [CODE_W-1:0] held_q,
  output logic [CODE_W-1:0] code_eff
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      held_q <= '0;
    else if (strobe) held_q <= data_in;
  end

  // open strobe passes data straight through
  assign code_eff = strobe ? data_in : held_q;
endmodule

// File: rtl/sld_onehot_dec.sv
module sld_onehot_dec #(
  parameter int CODE_W = 4,
  localparam int LINES = 1 << CODE_W
) (
  input  logic [CODE_W-1:0] code,
  output logic [LINES-1:0]  hit
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign hit[i] = (code == CODE_W'(i));
  end
endmodule

// File: rtl/sld_out_gate.sv
module sld_out_gate #(
  parameter int LINES = 16,
  parameter sld_pkg::pol_e POLARITY = sld_pkg::POL_HIGH
) (
  input  logic [LINES-1:0] hit,
  input  logic             inhibit,
  output logic [LINES-1:0] sel_out
);
  for (genvar i = 0; i < LINES; i++) begin : g_gate
    assign sel_out[i] = inhibit ? sld_pkg::idle_level(POLARITY)
                                : sld_pkg::line_level(hit[i], POLARITY);
  end
endmodule

// File: rtl/strobe_latch_decoder.sv
module strobe_latch_decoder #(
  parameter int CODE_W = 4,
  parameter sld_pkg::pol_e POLARITY = sld_pkg::POL_HIGH,
  localparam int LINES = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] data_in,
  input  logic              strobe,
  input  logic              inhibit,
  output logic [LINES-1:0]  sel_out
);
  logic [CODE_W-1:0] held_q;
  logic [CODE_W-1:0] code_eff;
  logic [LINES-1:0]  hit_vec;

  sld_code_hold #(.CODE_W(CODE_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .data_in(data_in),
    .held_q(held_q), .code_eff(code_eff)
  );

  sld_onehot_dec #(.CODE_W(CODE_W)) u_dec (
    .code(code_eff), .hit(hit_vec)
  );

  sld_out_gate #(.LINES(LINES), .POLARITY(POLARITY)) u_gate (
    .hit(hit_vec), .inhibit(inhibit), .sel_out(sel_out)
  );
endmodule

// File: rtl/sld_checker.sv
module sld_checker #(
  parameter int CODE_W = 4,
  parameter sld_pkg::pol_e POLARITY = sld_pkg::POL_HIGH,
  localparam int LINES = 1 << CODE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] data_in,
  input logic              strobe,
  input logic              inhibit,
  input logic [CODE_W-1:0] held_q,
  input logic [LINES-1:0]  sel_out
);
  localparam logic ACT = (POLARITY == sld_pkg::POL_HIGH);

  a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> held_q == '0);

  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> held_q == $past(data_in));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(held_q));

  a_r2_r9_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !inhibit) |-> sel_out[data_in] == ACT);

  a_r5_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    !inhibit |-> $countones(ACT ? sel_out : ~sel_out) == 1);

  a_r7_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |-> $countones(ACT ? sel_out : ~sel_out) == 0);

  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && !inhibit) |-> sel_out[held_q] == ACT);
endmodule

bind strobe_latch_decoder sld_checker #(.CODE_W(CODE_W), .POLARITY(POLARITY)) u_chk (
  .clk(clk), .rst_n(rst_n), .data_in(data_in), .strobe(strobe),
  .inhibit(inhibit), .held_q(held_q), .sel_out(sel_out)
);

// File: tb/test_strobe_latch_decoder.sv
module test_strobe_latch_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] data_in = 4'd0;
  logic strobe = 1'b0;
  logic inhibit = 1'b0;
  logic [15:0] out_hi, out_lo;
  int total = 0, bad = 0;
  int model_code = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  strobe_latch_decoder #(.CODE_W(4), .POLARITY(sld_pkg::POL_HIGH)) i_strobe_latch_decoder (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .strobe(strobe),
    .inhibit(inhibit), .sel_out(out_hi));

  strobe_latch_decoder #(.CODE_W(4), .POLARITY(sld_pkg::POL_LOW)) i_strobe_latch_decoder_n (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .strobe(strobe),
    .inhibit(inhibit), .sel_out(out_lo));

  function automatic logic [15:0] expect_bus(int code, bit inh, bit low);
    logic [15:0] v;
    for (int k = 0; k < 16; k++) begin
      if (inh) v[k] = low;
      else     v[k] = (k == code) ? !low : low;
    end
    return v;
  endfunction

  task automatic compare(string req);
    int code;
    logic [15:0] eh, el;
    code = strobe ? int'(data_in) : model_code;
    eh = expect_bus(code, inhibit, 1'b0);
    el = expect_bus(code, inhibit, 1'b1);
    total++;
    if (out_hi !== eh) begin
      bad++;
      $display("FAIL %s high-polarity: actual=%h expected=%h", req, out_hi, eh);
    end
    total++;
    if (out_lo !== el) begin
      bad++;
      $display("FAIL %s low-polarity: actual=%h expected=%h", req, out_lo, el);
    end
  endtask

  // drive at negedge, check mid-phase, update model at posedge
  task automatic step(input logic [3:0] d, input bit s, input bit inh, input string req);
    @(negedge clk);
    data_in = d; strobe = s; inhibit = inh;
    #1;
    compare(req);
    @(posedge clk);
    if (s) model_code = int'(d);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset leaves code 0 held
    step(4'd7, 1'b0, 1'b0, "R1");
    // R2 R9 R5 R6: every code with strobe open
    for (int c = 0; c < 16; c++) step(4'(c), 1'b1, 1'b0, "R2/R9");
    // R4: load 5, then data moves with strobe closed
    step(4'd5, 1'b1, 1'b0, "R3");
    for (int c = 0; c < 16; c++) step(4'(15 - c), 1'b0, 1'b0, "R4");
    // R3: single-cycle pulse holds that cycle's data
    step(4'd12, 1'b1, 1'b0, "R3");
    step(4'd3, 1'b0, 1'b0, "R3");
    step(4'd1, 1'b0, 1'b0, "R3");
    // R7: inhibit with strobe open and closed
    step(4'd9, 1'b1, 1'b1, "R7");
    step(4'd2, 1'b1, 1'b1, "R7");
    step(4'd14, 1'b0, 1'b1, "R7");
    step(4'd0, 1'b0, 1'b1, "R7");
    // R8: release shows held code (2 loaded while inhibited)
    step(4'd11, 1'b0, 1'b0, "R8");
    step(4'd6, 1'b1, 1'b0, "R3");
    step(4'd13, 1'b0, 1'b1, "R7");
    step(4'd4, 1'b0, 1'b1, "R7");
    step(4'd8, 1'b0, 1'b0, "R8");
    step(4'd15, 1'b1, 1'b0, "R2");
    step(4'd0, 1'b0, 1'b0, "R4");
    finish_run();
  end
endmodule